// File: doc/BRIEF.md
# Relative Branch Resolver with Condition Deposit

This block resolves relative branches for a small 8/16-bit processor core. Each cycle the core may present a branch with its condition selector, the current status flags, the accumulator, the address of the following instruction and a displacement. One clock later the block reports whether the branch is taken and the address to continue from.

Two prefix inputs change the branch. The first one is the stack-override prefix. It makes the branch also write its condition outcome into the accumulator as a boolean 1 or 0. Under that prefix the always-branch becomes a test of whether the accumulator is non-zero. The second prefix widens the displacement from a signed byte to a signed 16-bit word. The two prefixes can be used together. An accumulator-width input tells the block whether the accumulator currently works as 8 bits or as 16 bits.

Top module: `br_unit`

## Requirements
- R1: When `op_valid` is low at a clock edge, after that edge `br_taken` is 0, `acc_we` is 0 and `br_next_pc` equals the sampled `pc_next`.
- R2: All outputs are registered one clock after their inputs. While `rst_n` is low, `br_taken`, `br_next_pc`, `acc_we` and `acc_wdata` are all 0.
- R3: `op_cond` selects the condition. `flags` bits are {N,V,Z,C} at bits 3..0. The codes are: 0 N=0, 1 N=1, 2 V=0, 3 V=1, 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 always, 9 signed greater, 10 signed greater-or-equal (N==V), 11 signed less (N!=V), 12 signed less-or-equal (Z=1 or N!=V), 13 unsigned higher (C=1 and Z=0), 14 unsigned lower-or-same (C=0 or Z=1), 15 never.
- R4: Signed greater (code 9) is true exactly when Z=0 and N equals V.
- R5: A taken branch sets `br_next_pc` to `pc_next` plus the sign-extended `offset[7:0]`, modulo 2^16. A branch that is not taken sets it to `pc_next`.
- R6: With `pfx_w` high, the displacement is the full signed 16-bit `offset`.
- R7: Without `pfx_s`, a branch never writes the accumulator (`acc_we` stays 0).
- R8: With `pfx_s`, a branch raises `acc_we`. Bit 0 of `acc_wdata` is the condition outcome, and the branch is taken exactly when that outcome is 1.
- R9: With `pfx_s` and code 8, the condition is true only when the active accumulator is non-zero. In 8-bit mode (`acc_wide`=0) only `acc[7:0]` is tested.
- R10: In 16-bit mode, `acc_wdata[15:1]` is 0. In 8-bit mode, `acc_wdata[7:1]` is 0 and `acc_wdata[15:8]` carries `acc[15:8]` unchanged.
- R11: `pfx_s` and `pfx_w` combine: the deposit happens and the 16-bit displacement is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A relative branch is presented this cycle |
| op_cond | input | 4 | Condition selector |
| flags | input | 4 | Status flags {N,V,Z,C} |
| acc | input | 16 | Current accumulator |
| acc_wide | input | 1 | 1: accumulator is 16-bit, 0: 8-bit |
| pc_next | input | 16 | Address of the instruction after the branch |
| offset | input | 16 | Displacement; low byte used unless `pfx_w` |
| pfx_s | input | 1 | Stack-override prefix: deposit condition, conditional always-branch |
| pfx_w | input | 1 | Wide-displacement prefix |
| br_taken | output | 1 | Branch taken |
| br_next_pc | output | 16 | Address to continue from |
| acc_we | output | 1 | Accumulator write enable |
| acc_wdata | output | 16 | Accumulator write data |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 16-bit accumulator with an 8-bit narrow mode, and byte and word displacements. With these values the address can wrap past 0xFFFF and back below 0x0000 using a small byte displacement. Both accumulator widths can be tested, including an 8-bit accumulator whose low byte is zero while its upper byte is not. Every one of the sixteen condition codes is swept across all flag combinations.

// File: rtl/br_pkg.sv
// Shared types for the branch resolver: condition codes and flag layout.
package br_pkg;
    typedef enum logic [3:0] {
        CND_NPOS = 4'd0,
        CND_NNEG = 4'd1,
        CND_VCLR = 4'd2,
        CND_VSET = 4'd3,
        CND_CCLR = 4'd4,
        CND_CSET = 4'd5,
        CND_ZCLR = 4'd6,
        CND_ZSET = 4'd7,
        CND_ALW  = 4'd8,
        CND_SGT  = 4'd9,
        CND_SGE  = 4'd10,
        CND_SLT  = 4'd11,
        CND_SLE  = 4'd12,
        CND_UHI  = 4'd13,
        CND_ULS  = 4'd14,
        CND_NEVR = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;
endpackage

// File: rtl/br_cond_eval.sv
// Condition evaluator: decides the branch outcome from the selector and flags.
// Assumes flags are already settled for the presented instruction; purely
// combinational. Under the stack-override prefix the always code tests the
// accumulator non-zero indication instead.
module br_cond_eval
    import br_pkg::*;
(
    input  logic [3:0] cond_sel,
    input  flags_t     fl,
    input  logic       pfx_s,
    input  logic       acc_nz,
    output logic       hit
);
    // Map each condition code onto its flag test.
    always_comb begin
        case (cond_e'(cond_sel))
            CND_NPOS: hit = ~fl.n;
            CND_NNEG: hit = fl.n;
            CND_VCLR: hit = ~fl.v;
            CND_VSET: hit = fl.v;
            CND_CCLR: hit = ~fl.c;
            CND_CSET: hit = fl.c;
            CND_ZCLR: hit = ~fl.z;
            CND_ZSET: hit = fl.z;
            CND_ALW:  hit = pfx_s ? acc_nz : 1'b1;
            CND_SGT:  hit = ~fl.z & (fl.n ~^ fl.v);
            CND_SGE:  hit = fl.n ~^ fl.v;
            CND_SLT:  hit = fl.n ^ fl.v;
            CND_SLE:  hit = fl.z | (fl.n ^ fl.v);
            CND_UHI:  hit = fl.c & ~fl.z;
            CND_ULS:  hit = ~fl.c | fl.z;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
// Target adder: sign-extends the short or long displacement and adds it to
// the fall-through address. Wraps modulo 2^ADDR_W. Assumes SHORT_W < ADDR_W.
module br_target #(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [LONG_W-1:0] offset,
    input  logic              long_sel,
    output logic [ADDR_W-1:0] target
);
    localparam int SHORT_PAD = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] long_ext;

    // Sign-extend the byte displacement.
    always_comb short_ext = {{SHORT_PAD{offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};

    // Fit the long displacement to the address width.
    generate
        if (LONG_W >= ADDR_W) begin : g_long_trunc
            always_comb long_ext = offset[ADDR_W-1:0];
        end else begin : g_long_ext
            localparam int LONG_PAD = ADDR_W - LONG_W;
            always_comb long_ext = {{LONG_PAD{offset[LONG_W-1]}}, offset};
        end
    endgenerate

    // Add the selected displacement to the fall-through address.
    always_comb target = pc_next + (long_sel ? long_ext : short_ext);
endmodule

// File: rtl/br_deposit.sv
// Deposit formatter: builds the accumulator write word holding the boolean
// outcome, and reports whether the active accumulator is non-zero. In narrow
// mode the bits above the narrow width keep their present value.
module br_deposit #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic              wide,
    input  logic              hit,
    output logic              acc_nz,
    output logic [DATA_W-1:0] wdata
);
    localparam int HI_W = DATA_W - NARROW_W;

    // Non-zero test over the active width only.
    always_comb acc_nz = wide ? (|acc) : (|acc[NARROW_W-1:0]);

    // Zero-extend the outcome over the active width.
    always_comb begin
        if (wide)
            wdata = {{(DATA_W-1){1'b0}}, hit};
        else
            wdata = {acc[DATA_W-1:NARROW_W], {(NARROW_W-1){1'b0}}, hit};
    end

    logic unused_hi;
    always_comb unused_hi = (HI_W > 0);
endmodule

// File: rtl/br_unit.sv
// Relative branch resolver top. Samples a presented branch every cycle and,
// one clock later, reports taken, next address and an optional accumulator
// write carrying the condition outcome. Assumes the core holds inputs stable
// across the sampling edge; synchronous active-low reset.
module br_unit #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int SHORT_W  = 8,
    parameter int LONG_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_cond,
    input  logic [3:0]        flags,
    input  logic [DATA_W-1:0] acc,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [LONG_W-1:0] offset,
    input  logic              pfx_s,
    input  logic              pfx_w,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_next_pc,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_wdata
);
    import br_pkg::*;

    logic              acc_nz;
    logic              hit;
    logic [ADDR_W-1:0] target;
    logic [DATA_W-1:0] dep_word;
    logic              take_d;
    logic              wr_d;

    br_cond_eval u_cond (
        .cond_sel (op_cond),
        .fl       (flags_t'(flags)),
        .pfx_s    (pfx_s),
        .acc_nz   (acc_nz),
        .hit      (hit)
    );

    br_target #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) u_tgt (
        .pc_next  (pc_next),
        .offset   (offset),
        .long_sel (pfx_w),
        .target   (target)
    );

    br_deposit #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_dep (
        .acc    (acc),
        .wide   (acc_wide),
        .hit    (hit),
        .acc_nz (acc_nz),
        .wdata  (dep_word)
    );

    // Qualify outcome and write request with the branch strobe.
    always_comb begin
        take_d = op_valid & hit;
        wr_d   = op_valid & pfx_s;
    end

    // Register the resolved branch and the deposit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_taken   <= 1'b0;
            br_next_pc <= '0;
            acc_we     <= 1'b0;
            acc_wdata  <= '0;
        end else begin
            br_taken   <= take_d;
            br_next_pc <= take_d ? target : pc_next;
            acc_we     <= wr_d;
            acc_wdata  <= wr_d ? dep_word : '0;
        end
    end
endmodule

// File: rtl/br_unit_chk.sv
// Property checker for br_unit, attached by bind. Relates registered outputs
// to the inputs sampled one edge earlier.
module br_unit_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_cond,
    input logic [DATA_W-1:0] acc,
    input logic              acc_wide,
    input logic [ADDR_W-1:0] pc_next,
    input logic              pfx_s,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_next_pc,
    input logic              acc_we,
    input logic [DATA_W-1:0] acc_wdata
);
    logic acc_zero;
    always_comb acc_zero = acc_wide ? (acc == '0) : (acc[NARROW_W-1:0] == '0);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!br_taken && !acc_we)); // R1

    AST_FALLTHRU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (br_taken || br_next_pc == $past(pc_next))); // R5

    AST_NO_PFX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !pfx_s) |=> !acc_we); // R7

    AST_DEPOSIT_IS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (acc_wdata[0] == br_taken)); // R8

    AST_ALW_ZERO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && pfx_s && op_cond == 4'd8 && acc_zero) |=> !br_taken); // R9

    AST_WIDE_DEPOSIT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && pfx_s && acc_wide) |=> (acc_wdata[DATA_W-1:1] == '0)); // R10
endmodule

bind br_unit br_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_cond    (op_cond),
    .acc        (acc),
    .acc_wide   (acc_wide),
    .pc_next    (pc_next),
    .pfx_s      (pfx_s),
    .br_taken   (br_taken),
    .br_next_pc (br_next_pc),
    .acc_we     (acc_we),
    .acc_wdata  (acc_wdata)
);

// File: tb/sim_br_unit.sv
// Directed bench for br_unit: one task per scenario, each checks its own results.
module sim_br_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_cond = '0;
    logic [3:0]  flags = '0;
    logic [15:0] acc = '0;
    logic        acc_wide = 1'b1;
    logic [15:0] pc_next = '0;
    logic [15:0] offset = '0;
    logic        pfx_s = 1'b0;
    logic        pfx_w = 1'b0;
    logic        br_taken;
    logic [15:0] br_next_pc;
    logic        acc_we;
    logic [15:0] acc_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cond(op_cond),
        .flags(flags), .acc(acc), .acc_wide(acc_wide), .pc_next(pc_next),
        .offset(offset), .pfx_s(pfx_s), .pfx_w(pfx_w), .br_taken(br_taken),
        .br_next_pc(br_next_pc), .acc_we(acc_we), .acc_wdata(acc_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Expected condition from the table in the requirements (R3, R4, R9).
    function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f,
                                      input logic ps, input logic wide, input logic [15:0] a);
        logic n, v, z, cy, nz;
        n = f[3]; v = f[2]; z = f[1]; cy = f[0];
        nz = wide ? (a != 0) : (a[7:0] != 0);
        case (c)
            4'd0:  return !n;
            4'd1:  return n;
            4'd2:  return !v;
            4'd3:  return v;
            4'd4:  return !cy;
            4'd5:  return cy;
            4'd6:  return !z;
            4'd7:  return z;
            4'd8:  return ps ? nz : 1'b1;
            4'd9:  return !z && (n == v);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return z || (n != v);
            4'd13: return cy && !z;
            4'd14: return !cy || z;
            default: return 1'b0;
        endcase
    endfunction

    // Present one branch on a falling edge; outputs are sampled at the next falling edge.
    task automatic issue(input logic v, input logic [3:0] c, input logic [3:0] f,
                         input logic [15:0] a, input logic wide, input logic [15:0] pc,
                         input logic [15:0] off, input logic ps, input logic pw);
        @(negedge clk);
        op_valid = v; op_cond = c; flags = f; acc = a; acc_wide = wide;
        pc_next = pc; offset = off; pfx_s = ps; pfx_w = pw;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_valid = 1'b1; pfx_s = 1'b1; pc_next = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R2 reset taken", br_taken, 0);
        chk("R2 reset pc", br_next_pc, 0);
        chk("R2 reset we", acc_we, 0);
        chk("R2 reset wdata", acc_wdata, 0);
        op_valid = 1'b0; pfx_s = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        issue(1'b0, 4'd8, 4'h0, 16'h0001, 1'b1, 16'h4000, 16'h0010, 1'b1, 1'b0);
        chk("R1 idle taken", br_taken, 0);
        chk("R1 idle we", acc_we, 0);
        chk("R1 idle pc", br_next_pc, 16'h4000);
    endtask

    task automatic t_conds();
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic e;
                e = exp_cond(4'(c), 4'(f), 1'b0, 1'b1, 16'h0);
                issue(1'b1, 4'(c), 4'(f), 16'h0, 1'b1, 16'h2000, 16'h0020, 1'b0, 1'b0);
                chk($sformatf("R3 cond %0d flags %0h", c, f), br_taken, e);
                chk("R5 cond target", br_next_pc, e ? 16'h2020 : 16'h2000);
                chk("R7 no write", acc_we, 0);
            end
        end
        // R4 signed greater explicit corners: N=V=1,Z=0 true; N=1,V=0 false; Z=1 false.
        issue(1'b1, 4'd9, 4'b1100, 16'h0, 1'b1, 16'h0100, 16'h0004, 1'b0, 1'b0);
        chk("R4 gt n=v", br_taken, 1);
        issue(1'b1, 4'd9, 4'b1000, 16'h0, 1'b1, 16'h0100, 16'h0004, 1'b0, 1'b0);
        chk("R4 gt n!=v", br_taken, 0);
        issue(1'b1, 4'd9, 4'b0010, 16'h0, 1'b1, 16'h0100, 16'h0004, 1'b0, 1'b0);
        chk("R4 gt z", br_taken, 0);
    endtask

    task automatic t_target();
        issue(1'b1, 4'd8, 4'h0, 16'h0, 1'b1, 16'h0005, 16'h00F0, 1'b0, 1'b0);
        chk("R5 backward wrap", br_next_pc, 16'hFFF5);
        issue(1'b1, 4'd8, 4'h0, 16'h0, 1'b1, 16'hFFF0, 16'hAB7F, 1'b0, 1'b0);
        chk("R5 forward wrap high byte ignored", br_next_pc, 16'h006F);
    endtask

    task automatic t_long();
        issue(1'b1, 4'd8, 4'h0, 16'h0, 1'b1, 16'h1000, 16'h0300, 1'b0, 1'b1);
        chk("R6 long forward", br_next_pc, 16'h1300);
        issue(1'b1, 4'd8, 4'h0, 16'h0, 1'b1, 16'h1000, 16'hF000, 1'b0, 1'b1);
        chk("R6 long backward", br_next_pc, 16'h0000);
    endtask

    task automatic t_deposit();
        issue(1'b1, 4'd9, 4'b0000, 16'hBEEF, 1'b1, 16'h3000, 16'h0008, 1'b1, 1'b0);
        chk("R8 true we", acc_we, 1);
        chk("R8 true data", acc_wdata, 16'h0001);
        chk("R8 true taken", br_taken, 1);
        chk("R8 true pc", br_next_pc, 16'h3008);
        issue(1'b1, 4'd9, 4'b0010, 16'hBEEF, 1'b1, 16'h3000, 16'h0008, 1'b1, 1'b0);
        chk("R8 false we", acc_we, 1);
        chk("R8 false data", acc_wdata, 16'h0000);
        chk("R8 false taken", br_taken, 0);
        chk("R8 false pc", br_next_pc, 16'h3000);
    endtask

    task automatic t_always();
        issue(1'b1, 4'd8, 4'h0, 16'h0000, 1'b1, 16'h5000, 16'h0010, 1'b1, 1'b0);
        chk("R9 zero acc not taken", br_taken, 0);
        chk("R9 zero acc data", acc_wdata, 16'h0000);
        issue(1'b1, 4'd8, 4'h0, 16'h0100, 1'b1, 16'h5000, 16'h0010, 1'b1, 1'b0);
        chk("R9 wide nonzero taken", br_taken, 1);
        chk("R9 wide nonzero pc", br_next_pc, 16'h5010);
        issue(1'b1, 4'd8, 4'h0, 16'h1200, 1'b0, 16'h5000, 16'h0010, 1'b1, 1'b0);
        chk("R9 narrow low zero not taken", br_taken, 0);
        issue(1'b1, 4'd8, 4'h0, 16'h0003, 1'b0, 16'h5000, 16'h0010, 1'b1, 1'b0);
        chk("R9 narrow nonzero taken", br_taken, 1);
    endtask

    task automatic t_narrow();
        issue(1'b1, 4'd7, 4'b0010, 16'hA5C3, 1'b0, 16'h6000, 16'h0002, 1'b1, 1'b0);
        chk("R10 narrow keeps upper", acc_wdata, 16'hA501);
        issue(1'b1, 4'd7, 4'b0000, 16'hA5C3, 1'b0, 16'h6000, 16'h0002, 1'b1, 1'b0);
        chk("R10 narrow false", acc_wdata, 16'hA500);
        issue(1'b1, 4'd7, 4'b0010, 16'hA5C3, 1'b1, 16'h6000, 16'h0002, 1'b1, 1'b0);
        chk("R10 wide zero upper", acc_wdata, 16'h0001);
    endtask

    task automatic t_combo();
        issue(1'b1, 4'd13, 4'b0001, 16'h7777, 1'b1, 16'h0800, 16'hFE00, 1'b1, 1'b1);
        chk("R11 combo taken", br_taken, 1);
        chk("R11 combo pc", br_next_pc, 16'h0600);
        chk("R11 combo we", acc_we, 1);
        chk("R11 combo data", acc_wdata, 16'h0001);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_conds();
        t_target();
        t_long();
        t_deposit();
        t_always();
        t_narrow();
        t_combo();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule